// File: doc/BRIEF.md
# PLL Power-Up Sequencer with Processor Voting

This block drives the three mode-control pins of an analog PLL: bypass-disable, an active-low reset and output-enable. In software mode a three-bit mode word is written directly and appears on the pins. In hardware vote mode an internal sequencer takes over. Whenever any processor's vote bit is set, it orders the bypass, reset and output steps on its own, with all delays counted in prescaled ticks. When the last vote goes away, it drops all three pins in a single step.

Three orderings are selectable. The first releases bypass, then reset, and then polls the PLL's lock indication; if lock never comes, it reports a timeout. The second uses a fixed lock delay instead of polling. The third releases reset before bypass and then uses a longer fixed delay. A configuration word sets the programmable bias count, waited out after both bypass and reset are released, and the programmable settle count, waited out after the lock phase. The same word holds the vote enable and a reset for the sequencer. One tick is `PRESC_DIV` clock cycles, so the delay parameters are in microseconds when `PRESC_DIV` equals the reference clock frequency in MHz.

Top module: `pll_seq_top`

## Requirements
- R1: Mode word bit 0 drives `pll_out_en`, bit 1 drives `pll_byp_dis` and bit 2 drives `pll_rst_n`. With voting disabled, a `mode_wr` pulse loads `mode_wdata` and the pins show it on the next cycle.
- R2: `pll_enabled` is high exactly when all three mode bits are set.
- R3: Reset leaves all pins low, `seq_state` at 0, `pll_on` and `lock_timeout` low, and the configuration at: sequencer reset bit 21 = 1, vote enable bit 20 = 0, bias count bits 19:14 = 1, settle count bits 13:8 = 8, ordering bits 1:0 = 0.
- R4: While vote enable is set, `mode_wr` has no effect on the pins.
- R5: Ordering 0 runs as follows. On the first vote, bypass-disable rises. `GAP_TICKS` ticks later, reset is released. After the bias count, the lock input is polled (through two synchronizer stages). Once lock is seen, the settle count is waited out and then output-enable rises.
- R6: In ordering 0, if lock is not seen within `POLL_TICKS` ticks, the state becomes FAIL, `lock_timeout` is set and output-enable stays low. `lock_timeout` holds through power-down and clears when the next sequence starts.
- R7: Ordering 1 ignores the lock input and waits a fixed `FIXED_TICKS` ticks in the lock phase.
- R8: Ordering 2 releases reset first (pins 100), sets bypass-disable `GAP_TICKS` ticks later, and waits a fixed `REVERSE_TICKS` ticks in the lock phase.
- R9: `pll_on` is set from sequence start until power-down. Power-down happens only when every vote bit is clear; it clears all three pins on the next cycle.
- R10: While the sequencer reset bit is set and voting is enabled, the state stays 0 and the pins stay low, whatever the votes.
- R11: `seq_state` encodes OFF=0, GAP=1, BIAS=2, LOCK=3, SETTLE=4, ON=5, FAIL=6. A wait of N ticks leaves a state exactly N*`PRESC_DIV` cycles after entering it, and a count of 0 leaves it after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| mode_wr | input | 1 | Mode word write strobe |
| mode_wdata | input | 3 | Mode word (bit2 reset_n, bit1 bypass-disable, bit0 output-enable) |
| votes | input | NUM_VOTERS | Per-processor enable votes |
| pll_lock | input | 1 | Asynchronous lock indication from the PLL |
| pll_out_en | output | 1 | PLL output enable |
| pll_byp_dis | output | 1 | PLL bypass disable |
| pll_rst_n | output | 1 | PLL active-low reset |
| pll_enabled | output | 1 | All three mode bits set |
| pll_on | output | 1 | Sequencer has powered the PLL up |
| lock_timeout | output | 1 | Lock polling timed out |
| seq_state | output | 3 | Current sequencer state |

## Verification
Every register-driven output follows its stimulus edge by exactly one clock: the mode pins, `seq_state`, `pll_on` and `lock_timeout` all change at the edge that samples the write, the vote change or the end of a wait. A wait of N ticks ends N*`PRESC_DIV` edges after its state is entered, and the lock input reaches the sequencer two edges after it changes. The bench's behavioural model advances on the same rising edge as the design. It compares all outputs at the falling edge of every cycle, and the directed checks sample one falling edge after the input they follow.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_GAP    = 3'd1,
        ST_BIAS   = 3'd2,
        ST_LOCK   = 3'd3,
        ST_SETTLE = 3'd4,
        ST_ON     = 3'd5,
        ST_FAIL   = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        ORD_POLL     = 2'd0,
        ORD_FIXED    = 2'd1,
        ORD_RSTFIRST = 2'd2,
        ORD_SPARE    = 2'd3
    } order_e;

    // Mode word: bit2 reset_n, bit1 bypass-disable, bit0 output-enable
    typedef struct packed {
        logic rst_n;
        logic byp_dis;
        logic out_en;
    } mode_t;

    localparam int CNT_FIELD_W = 6;

    typedef struct packed {
        logic                   fsm_rst;
        logic                   vote_en;
        logic [CNT_FIELD_W-1:0] bias_cnt;
        logic [CNT_FIELD_W-1:0] settle_cnt;
        order_e                 order;
    } cfg_t;

    localparam int CFG_FSM_RST_BIT = 21;
    localparam int CFG_VOTE_BIT    = 20;
    localparam int CFG_BIAS_LSB    = 14;
    localparam int CFG_SETTLE_LSB  = 8;
    localparam int CFG_ORDER_LSB   = 0;

    function automatic cfg_t cfg_decode(input logic [31:0] w);
        cfg_t c;
        c.fsm_rst    = w[CFG_FSM_RST_BIT];
        c.vote_en    = w[CFG_VOTE_BIT];
        c.bias_cnt   = w[CFG_BIAS_LSB +: CNT_FIELD_W];
        c.settle_cnt = w[CFG_SETTLE_LSB +: CNT_FIELD_W];
        c.order      = order_e'(w[CFG_ORDER_LSB +: 2]);
        return c;
    endfunction

    function automatic cfg_t cfg_reset_value();
        cfg_t c;
        c.fsm_rst    = 1'b1;
        c.vote_en    = 1'b0;
        c.bias_cnt   = CNT_FIELD_W'(1);
        c.settle_cnt = CNT_FIELD_W'(8);
        c.order      = ORD_POLL;
        return c;
    endfunction

    function automatic logic order_polls(input order_e o);
        return (o == ORD_POLL) || (o == ORD_SPARE);
    endfunction

    function automatic mode_t pins_for_state(input seq_state_e s, input order_e o);
        mode_t m;
        m = '0;
        case (s)
            ST_OFF:    m = '0;
            ST_GAP: begin
                if (o == ORD_RSTFIRST) m.rst_n   = 1'b1;
                else                   m.byp_dis = 1'b1;
            end
            ST_BIAS, ST_LOCK, ST_SETTLE, ST_FAIL: begin
                m.rst_n   = 1'b1;
                m.byp_dis = 1'b1;
            end
            ST_ON: begin
                m.rst_n   = 1'b1;
                m.byp_dis = 1'b1;
                m.out_en  = 1'b1;
            end
            default:   m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pll_tick_gen.sv
module pll_tick_gen #(
    parameter int PRESC_DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int PCNT_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

    generate
        if (PRESC_DIV <= 1) begin : g_div1
            assign tick = 1'b1;
        end else begin : g_divn
            localparam logic [PCNT_W-1:0] LAST = PCNT_W'(PRESC_DIV - 1);
            logic [PCNT_W-1:0] pcnt_q;

            assign tick = (pcnt_q == LAST);

            always_ff @(posedge clk) begin
                if (rst || restart || tick) pcnt_q <= '0;
                else                        pcnt_q <= pcnt_q + 1'b1;
            end

            AST_TICK_AFTER_RESTART: assert property (@(posedge clk) disable iff (rst)
                restart |=> !tick);  // R11
        end
    endgenerate
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
    import pll_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output cfg_t        cfg
);
    cfg_t cfg_q;
    logic cfg_unused_bits;

    assign cfg_unused_bits = ^{cfg_wdata[31:22], cfg_wdata[7:2]};

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= cfg_reset_value();
        else if (cfg_wr) cfg_q <= cfg_decode(cfg_wdata);
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_async,
    output logic lock_sync
);
    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= lock_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], lock_async};
            end
        end
    endgenerate

    assign lock_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int GAP_TICKS     = 5,
    parameter int FIXED_TICKS   = 50,
    parameter int REVERSE_TICKS = 60,
    parameter int POLL_TICKS    = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  cfg_t       cfg,
    input  logic       any_vote,
    input  logic       lock_s,
    input  logic       tick,
    input  logic       mode_wr,
    input  mode_t      mode_wdata,
    output logic       restart,
    output seq_state_e state_o,
    output mode_t      mode_o,
    output logic       on_o,
    output logic       timeout_o
);
    localparam int MAX_A   = (GAP_TICKS > FIXED_TICKS) ? GAP_TICKS : FIXED_TICKS;
    localparam int MAX_B   = (REVERSE_TICKS > POLL_TICKS) ? REVERSE_TICKS : POLL_TICKS;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_ALL = (MAX_C > 63) ? MAX_C : 63;
    localparam int CNT_W   = $clog2(MAX_ALL + 1);

    localparam logic [CNT_W-1:0] GAP_L   = CNT_W'(GAP_TICKS);
    localparam logic [CNT_W-1:0] FIXED_L = CNT_W'(FIXED_TICKS);
    localparam logic [CNT_W-1:0] REV_L   = CNT_W'(REVERSE_TICKS);
    localparam logic [CNT_W-1:0] POLL_L  = CNT_W'(POLL_TICKS);

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] wait_len;
    logic             done;
    logic             hw_active;
    logic             polling;
    mode_t            mode_q;
    logic             on_q, timeout_q;

    assign hw_active = cfg.vote_en && !cfg.fsm_rst;
    assign polling   = order_polls(cfg.order);

    always_comb begin
        case (st_q)
            ST_GAP:    wait_len = GAP_L;
            ST_BIAS:   wait_len = CNT_W'(cfg.bias_cnt);
            ST_LOCK: begin
                if (polling)                       wait_len = POLL_L;
                else if (cfg.order == ORD_FIXED)   wait_len = FIXED_L;
                else                               wait_len = REV_L;
            end
            ST_SETTLE: wait_len = CNT_W'(cfg.settle_cnt);
            default:   wait_len = '0;
        endcase
    end

    assign done = (wait_len == '0) || (tick && (cnt_q == (wait_len - CNT_W'(1))));

    always_comb begin
        st_d = st_q;
        if (!hw_active) begin
            st_d = ST_OFF;
        end else if ((st_q != ST_OFF) && !any_vote) begin
            st_d = ST_OFF;
        end else begin
            case (st_q)
                ST_OFF:    if (any_vote) st_d = ST_GAP;
                ST_GAP:    if (done) st_d = ST_BIAS;
                ST_BIAS:   if (done) st_d = ST_LOCK;
                ST_LOCK: begin
                    if (polling && lock_s) st_d = ST_SETTLE;
                    else if (done)         st_d = polling ? ST_FAIL : ST_SETTLE;
                end
                ST_SETTLE: if (done) st_d = ST_ON;
                default:   st_d = st_q;
            endcase
        end
    end

    assign restart = (st_d != st_q);

    always_comb begin
        if (restart)   cnt_d = '0;
        else if (tick) cnt_d = cnt_q + CNT_W'(1);
        else           cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_OFF;
            cnt_q     <= '0;
            mode_q    <= '0;
            on_q      <= 1'b0;
            timeout_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            on_q  <= (st_d != ST_OFF);
            if (cfg.vote_en)  mode_q <= hw_active ? pins_for_state(st_d, cfg.order) : '0;
            else if (mode_wr) mode_q <= mode_wdata;
            if ((st_q == ST_OFF) && (st_d == ST_GAP))       timeout_q <= 1'b0;
            else if ((st_d == ST_FAIL) && (st_q != ST_FAIL)) timeout_q <= 1'b1;
        end
    end

    assign state_o   = st_q;
    assign mode_o    = mode_q;
    assign on_o      = on_q;
    assign timeout_o = timeout_q;

    AST_OUT_AFTER_PREP: assert property (@(posedge clk) disable iff (rst)
        (hw_active && $rose(mode_q.out_en)) |-> ($past(mode_q.rst_n) && $past(mode_q.byp_dis)));  // R5
    AST_FAIL_OUT_LOW: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FAIL) |-> !mode_q.out_en);  // R6
    AST_TIMEOUT_FROM_FAIL: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_q) |-> (st_q == ST_FAIL));  // R6
    AST_RSTFIRST_ORDER: assert property (@(posedge clk) disable iff (rst)
        (hw_active && (cfg.order == ORD_RSTFIRST) && $rose(mode_q.byp_dis)) |-> $past(mode_q.rst_n));  // R8
    AST_DROP_POWERS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (hw_active && !any_vote && (st_q != ST_OFF)) |=> ((mode_q == '0) && !on_q));  // R9
    AST_FSM_RST_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cfg.vote_en && cfg.fsm_rst) |=> ((st_q == ST_OFF) && (mode_q == '0)));  // R10
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        st_q != 3'd7);  // R11
endmodule

// File: rtl/pll_seq_top.sv
module pll_seq_top
    import pll_seq_pkg::*;
#(
    parameter int PRESC_DIV     = 50,
    parameter int GAP_TICKS     = 5,
    parameter int FIXED_TICKS   = 50,
    parameter int REVERSE_TICKS = 60,
    parameter int POLL_TICKS    = 200,
    parameter int NUM_VOTERS    = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  logic [31:0]           cfg_wdata,
    input  logic                  mode_wr,
    input  logic [2:0]            mode_wdata,
    input  logic [NUM_VOTERS-1:0] votes,
    input  logic                  pll_lock,
    output logic                  pll_out_en,
    output logic                  pll_byp_dis,
    output logic                  pll_rst_n,
    output logic                  pll_enabled,
    output logic                  pll_on,
    output logic                  lock_timeout,
    output logic [2:0]            seq_state
);
    cfg_t       cfg;
    logic       tick, restart, lock_s;
    seq_state_e st;
    mode_t      mode;

    pll_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    pll_tick_gen #(.PRESC_DIV(PRESC_DIV)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick)
    );

    pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .lock_async (pll_lock),
        .lock_sync  (lock_s)
    );

    pll_seq_fsm #(
        .GAP_TICKS     (GAP_TICKS),
        .FIXED_TICKS   (FIXED_TICKS),
        .REVERSE_TICKS (REVERSE_TICKS),
        .POLL_TICKS    (POLL_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .any_vote   (|votes),
        .lock_s     (lock_s),
        .tick       (tick),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_t'(mode_wdata)),
        .restart    (restart),
        .state_o    (st),
        .mode_o     (mode),
        .on_o       (pll_on),
        .timeout_o  (lock_timeout)
    );

    assign pll_out_en  = mode.out_en;
    assign pll_byp_dis = mode.byp_dis;
    assign pll_rst_n   = mode.rst_n;
    assign pll_enabled = mode.out_en & mode.byp_dis & mode.rst_n;
    assign seq_state   = st;
endmodule

// File: tb/pll_seq_top_bench.sv
`timescale 1ns/1ps
module pll_seq_top_bench;
    localparam int P     = 4;
    localparam int GAP   = 5;
    localparam int FIX   = 50;
    localparam int REV   = 60;
    localparam int POLL  = 200;
    localparam int NV    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic          mode_wr = 1'b0;
    logic [2:0]    mode_wdata = '0;
    logic [NV-1:0] votes = '0;
    logic          pll_lock;
    logic          pll_out_en, pll_byp_dis, pll_rst_n, pll_enabled, pll_on, lock_timeout;
    logic [2:0]    seq_state;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit cmp_on   = 0;

    always #10 clk = ~clk;  // 50 MHz

    pll_seq_top #(
        .PRESC_DIV(P), .GAP_TICKS(GAP), .FIXED_TICKS(FIX),
        .REVERSE_TICKS(REV), .POLL_TICKS(POLL), .NUM_VOTERS(NV), .SYNC_STAGES(2)
    ) u_pll_seq_top (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .votes(votes), .pll_lock(pll_lock),
        .pll_out_en(pll_out_en), .pll_byp_dis(pll_byp_dis), .pll_rst_n(pll_rst_n),
        .pll_enabled(pll_enabled), .pll_on(pll_on), .lock_timeout(lock_timeout),
        .seq_state(seq_state)
    );

    // Analog PLL stand-in: locks a set number of cycles after bypass and reset are released
    int lock_delay = 30;
    bit pll_broken = 0;
    int lk_cnt = 0;
    always @(posedge clk) begin
        if (pll_rst_n === 1'b1 && pll_byp_dis === 1'b1 && !pll_broken) begin
            if (lk_cnt < lock_delay) lk_cnt <= lk_cnt + 1;
        end else begin
            lk_cnt <= 0;
        end
    end
    assign pll_lock = !pll_broken && (lk_cnt >= lock_delay);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model (states as integers, waits as cycle countdowns)
    int       m_st = 0;
    int       m_rem = 0;
    logic [2:0] m_mode = '0;
    bit       m_to = 0, m_s1 = 0, m_s2 = 0;
    bit       c_frst = 1, c_ven = 0;
    int       c_bias = 1, c_settle = 8, c_ord = 0;

    function automatic logic [2:0] exp_pins(input int st, input int ord);
        if (st == 0) return 3'b000;
        if (st == 1) return (ord == 2) ? 3'b100 : 3'b010;
        if (st == 5) return 3'b111;
        return 3'b110;
    endfunction

    function automatic int wait_cycles(input int st);
        int n;
        n = 0;
        if (st == 1) n = GAP;
        else if (st == 2) n = c_bias;
        else if (st == 3) n = (c_ord == 1) ? FIX : (c_ord == 2) ? REV : POLL;
        else if (st == 4) n = c_settle;
        return (n * P < 1) ? 1 : n * P;
    endfunction

    always @(posedge clk) begin
        int nxt;
        bit hw, poll;
        if (rst) begin
            m_st = 0; m_rem = 0; m_mode = '0; m_to = 0; m_s1 = 0; m_s2 = 0;
            c_frst = 1; c_ven = 0; c_bias = 1; c_settle = 8; c_ord = 0;
        end else begin
            hw   = c_ven && !c_frst;
            poll = (c_ord == 0) || (c_ord == 3);
            nxt  = m_st;
            if (!hw) nxt = 0;
            else if (m_st != 0 && votes == '0) nxt = 0;
            else if (m_st == 0) begin
                if (votes != '0) nxt = 1;
            end else if (m_st == 3 && poll) begin
                if (m_s2) nxt = 4;
                else begin
                    m_rem--;
                    if (m_rem <= 0) nxt = 6;
                end
            end else if (m_st >= 1 && m_st <= 4) begin
                m_rem--;
                if (m_rem <= 0) nxt = m_st + 1;
            end
            if (nxt != m_st) m_rem = wait_cycles(nxt);
            if (m_st == 0 && nxt == 1) m_to = 0;
            else if (nxt == 6 && m_st != 6) m_to = 1;
            if (c_ven) m_mode = hw ? exp_pins(nxt, c_ord) : 3'b000;
            else if (mode_wr) m_mode = mode_wdata;
            m_st = nxt;
            m_s2 = m_s1;
            m_s1 = pll_lock;
            if (cfg_wr) begin
                c_frst   = cfg_wdata[21];
                c_ven    = cfg_wdata[20];
                c_bias   = int'(cfg_wdata[19:14]);
                c_settle = int'(cfg_wdata[13:8]);
                c_ord    = int'(cfg_wdata[1:0]);
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            chk("R11 seq_state vs model", 32'(seq_state), 32'(m_st));
            chk("R1 pins vs model", 32'({pll_rst_n, pll_byp_dis, pll_out_en}), 32'(m_mode));
            chk("R2 enabled vs model", 32'(pll_enabled), 32'(&m_mode));
            chk("R9 on flag vs model", 32'(pll_on), 32'(m_st != 0));
            chk("R6 timeout vs model", 32'(lock_timeout), 32'(m_to));
        end
    end

    // Rising-edge timestamps of the pins for the gap check
    int t_byp = -1, t_rst = -1;
    logic p_byp = 0, p_rst = 0;
    always @(negedge clk) begin
        if (pll_byp_dis === 1'b1 && !p_byp) t_byp = cyc;
        if (pll_rst_n === 1'b1 && !p_rst) t_rst = cyc;
        p_byp = (pll_byp_dis === 1'b1);
        p_rst = (pll_rst_n === 1'b1);
    end

    function automatic logic [31:0] mk_cfg(input bit frst, input bit ven, input int bias,
                                           input int settle, input int ord);
        logic [31:0] w;
        w = '0;
        w[21] = frst;
        w[20] = ven;
        w[19:14] = 6'(bias);
        w[13:8] = 6'(settle);
        w[1:0] = 2'(ord);
        return w;
    endfunction

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic write_mode(input logic [2:0] m);
        @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic set_votes(input logic [NV-1:0] v);
        @(negedge clk); votes = v;
    endtask

    task automatic wait_state(input string tag, input int st, input int max_cyc);
        int k;
        k = 0;
        while (seq_state !== 3'(st) && k < max_cyc) begin
            @(negedge clk);
            k++;
        end
        chk(tag, 32'(seq_state), 32'(st));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1;
        // R3: reset state
        chk("R3 reset pins", 32'({pll_rst_n, pll_byp_dis, pll_out_en}), 32'd0);
        chk("R3 reset state", 32'(seq_state), 32'd0);
        chk("R3 reset flags", 32'({pll_on, lock_timeout}), 32'd0);

        // R1/R2/R3: software mode is the reset default
        write_mode(3'b010);
        chk("R1 sw write bypass only", 32'({pll_rst_n, pll_byp_dis, pll_out_en}), 32'b010);
        chk("R2 not enabled with one bit", 32'(pll_enabled), 32'd0);
        write_mode(3'b111);
        chk("R2 enabled with all bits", 32'(pll_enabled), 32'd1);
        write_mode(3'b101);
        chk("R2 not enabled without bypass", 32'(pll_enabled), 32'd0);
        write_mode(3'b000);

        // R10: sequencer reset held (default) while voting enabled
        write_cfg(mk_cfg(1, 1, 1, 8, 0));
        set_votes(4'b0010);
        repeat (20) @(negedge clk);
        chk("R10 held state", 32'(seq_state), 32'd0);
        chk("R10 held pins", 32'({pll_rst_n, pll_byp_dis, pll_out_en}), 32'd0);

        // R4: software writes ignored while voting enabled
        write_mode(3'b111);
        chk("R4 write ignored", 32'({pll_rst_n, pll_byp_dis, pll_out_en}), 32'd0);

        // R5: polled ordering with lock
        lock_delay = 30;
        write_cfg(mk_cfg(0, 1, 1, 8, 0));
        wait_state("R5 reaches ON", 5, 2000);
        chk("R5 pins all set", 32'({pll_rst_n, pll_byp_dis, pll_out_en}), 32'b111);
        chk("R5 bypass-to-reset gap", 32'(t_rst - t_byp), 32'(GAP * P));
        chk("R9 on flag while up", 32'(pll_on), 32'd1);

        // R9: a remaining vote keeps it up; last vote drop powers down in one step
        set_votes(4'b0011);
        set_votes(4'b0001);
        repeat (5) @(negedge clk);
        chk("R9 still ON with one vote", 32'(seq_state), 32'd5);
        set_votes(4'b0000);
        @(negedge clk);
        chk("R9 one-step power down", 32'({pll_rst_n, pll_byp_dis, pll_out_en}), 32'd0);
        chk("R9 on flag cleared", 32'(pll_on), 32'd0);

        // R6: lock never arrives
        pll_broken = 1;
        set_votes(4'b0100);
        wait_state("R6 reaches FAIL", 6, 3000);
        chk("R6 timeout flag", 32'(lock_timeout), 32'd1);
        chk("R6 output stays low", 32'(pll_out_en), 32'd0);
        set_votes(4'b0000);
        @(negedge clk);
        chk("R6 timeout sticky after power down", 32'(lock_timeout), 32'd1);
        pll_broken = 0;
        set_votes(4'b1000);
        @(negedge clk);
        chk("R6 timeout cleared on restart", 32'(lock_timeout), 32'd0);
        wait_state("R6 recovers to ON", 5, 2000);
        set_votes(4'b0000);
        @(negedge clk);

        // R7: fixed delay ignores lock
        write_cfg(mk_cfg(0, 1, 1, 8, 1));
        pll_broken = 1;
        set_votes(4'b0010);
        wait_state("R7 fixed delay reaches ON", 5, 2000);
        chk("R7 output set without lock", 32'(pll_out_en), 32'd1);
        set_votes(4'b0000);
        @(negedge clk);
        pll_broken = 0;

        // R8: reset-first ordering
        write_cfg(mk_cfg(0, 1, 1, 8, 2));
        set_votes(4'b0001);
        @(negedge clk);
        chk("R8 reset released first", 32'({pll_rst_n, pll_byp_dis, pll_out_en}), 32'b100);
        wait_state("R8 reaches ON", 5, 2000);
        chk("R8 reset-to-bypass gap", 32'(t_byp - t_rst), 32'(GAP * P));
        set_votes(4'b0000);
        @(negedge clk);

        // R11: zero bias and settle counts each last one cycle
        write_cfg(mk_cfg(0, 1, 0, 0, 1));
        set_votes(4'b0100);
        wait_state("R11 zero counts reach ON", 5, 2000);
        set_votes(4'b0000);
        repeat (3) @(negedge clk);
        chk("R11 back to OFF", 32'(seq_state), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule